// File: doc/BRIEF.md
# Multi-Source Reset Supervisor with Power-Up Hold Timer

This block combines nine reset causes into one chip-wide reset output. The causes are power-on, the external reset pin while running, the external reset pin while in a low-power state, watchdog timeout, brown-out, configuration-word mismatch, the software reset command, stack overflow and stack underflow. Any active request sets a hold latch at once. The latch lets go only after a hold counter has seen a set number of ticks of the slow internal oscillator, counted after the last request went away. That delay keeps the chip in reset until the supply and the clocks have settled.

Each request is brought into the system clock domain by a two-stage synchronizer. The reset pin asserts through the asynchronous reset of its synchronizer, so it takes effect at the first clock edge, and its release is synchronous. A small register window holds three things. The first is a set of sticky event flags that software can only clear. The second is a read/write interrupt-priority enable bit that no reset flag affects. The third is a read-only record of every cause seen during the most recent reset episode.

Top module: `reset_supervisor`

## Requirements
- R1: A request from any source, held for at least one clock cycle, drives `chip_rst` high no later than the third rising clock edge after it is applied. A single-cycle pulse is enough.
- R2: `chip_rst` falls only after `TERM_TICKS` pulses of `rc_tick` have been counted while no request is active. The release comes one clock after the last counted tick. Any new request restarts the count from zero.
- R3: When `vreg_en` is low, a brown-out request has no effect: it does not assert `chip_rst`, does not set a flag and does not change the cause record.
- R4: Status word (`reg_addr`=0) bits 4:0 are sticky flags. The bits are: bit0 brown-out, bit1 power-on, bit2 entry into the low-power state (rising edge of `sleep_active`), bit3 watchdog, bit4 software reset. Bits 6:5 and 15:8 read as zero.
- R5: A write to the status word changes each flag to flag AND written bit, so software can clear a flag but never set one. If an event and a write to its flag fall in the same cycle, the event wins.
- R6: A power-on request leaves exactly the power-on flag set (status bits 4:0 = 00010) and clears the priority enable bit. This holds even when other events happen in the same cycle.
- R7: Status bit 7 is a read/write priority-enable bit. No reset cause changes it except power-on.
- R8: The cause word (`reg_addr`=1) is read-only. Its bits are: 0 power-on, 1 pin while running, 2 pin while `sleep_active`, 3 watchdog, 4 brown-out, 5 configuration mismatch, 6 software reset, 7 stack full, 8 stack underflow. The first request of a new episode (while `chip_rst` is low) replaces the record. Later requests in the same episode are ORed in. Writes to this word are ignored.
- R9: Driving `pin_rst_n` low sets `chip_rst` high at the next rising clock edge, with no synchronizer delay. The running or low-power state at that moment decides which cause bit is recorded.
- R10: When several requests are active in the same cycle, all of their flags and cause bits are set together.
- R11: While `arst_n` is low, `chip_rst` is high and the status and cause words read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low reset of the block itself |
| rc_tick | input | 1 | One-cycle pulse per period of the slow internal oscillator |
| por_req | input | 1 | Power-on pulse from the supply-rise detector |
| pin_rst_n | input | 1 | External reset pin, active low |
| wdt_req | input | 1 | Watchdog timeout request |
| bor_req | input | 1 | Brown-out request |
| vreg_en | input | 1 | Regulator-enable strap; brown-out is honoured only when high |
| cfg_mismatch_req | input | 1 | Configuration-word mismatch request |
| swrst_req | input | 1 | Software reset command request |
| stk_full_req | input | 1 | Stack overflow request |
| stk_under_req | input | 1 | Stack underflow request |
| sleep_active | input | 1 | High while the core is in a low-power state |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Word select: 0 status, 1 cause record |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected word |
| chip_rst | output | 1 | Synchronous chip reset, active high |

## Verification
The bench builds the block with `TERM_TICKS` = 5 and the default two synchronizer stages. With this short count, every release can be reached in a few dozen cycles. The exact boundary between `TERM_TICKS`-1 and `TERM_TICKS` counted ticks is tested directly, and so is a restart of the count partway through. A table walks each cause alone, the brown-out gate and two combined-request vectors. Directed tests then cover the edge latency, the rule that writes can only clear, power-on dominance, the retention of the priority bit and the asynchronous pin path.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int REG_W   = 16;
  localparam int FLAG_W  = 5;
  localparam int CAUSE_W = 9;
  localparam int PRIO_BIT = 7;

  // status flag positions
  localparam int FL_BOR   = 0;
  localparam int FL_POR   = 1;
  localparam int FL_SLEEP = 2;
  localparam int FL_WDT   = 3;
  localparam int FL_SWRST = 4;

  // cause record positions
  localparam int CS_POR      = 0;
  localparam int CS_PIN_RUN  = 1;
  localparam int CS_PIN_SLP  = 2;
  localparam int CS_WDT      = 3;
  localparam int CS_BOR      = 4;
  localparam int CS_CFG      = 5;
  localparam int CS_SWRST    = 6;
  localparam int CS_STK_FULL = 7;
  localparam int CS_STK_UNDR = 8;

  localparam logic [FLAG_W-1:0] FLAGS_AFTER_POR = FLAG_W'(1) << FL_POR;
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] stg_q;
    logic [W-1:0] stg_d;
    if (g == 0) begin : g_first
      assign stg_d = d;
    end else begin : g_next
      assign stg_d = g_stage[g-1].stg_q;
    end
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) stg_q <= RST_VAL;
      else         stg_q <= stg_d;
    end
  end
  assign q = g_stage[STAGES-1].stg_q;
endmodule

// File: rtl/rstc_timer.sv
module rstc_timer #(
  parameter int TERM_TICKS = 2048,
  localparam int CNT_W = $clog2(TERM_TICKS + 1)
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             tick,
  output logic             expired,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] TERM_V = CNT_W'(TERM_TICKS);

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign expired = (cnt == TERM_V);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt;
    if (restart || !run) begin
      cnt_en = (cnt != '0);
      cnt_d  = '0;
    end else if (tick && !expired) begin
      cnt_en = 1'b1;
      cnt_d  = cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end
endmodule

// File: rtl/rstc_status.sv
module rstc_status
  import rstc_pkg::*;
(
  input  logic               clk,
  input  logic               arst_n,
  input  logic               por_evt,
  input  logic [FLAG_W-1:0]  flag_set,
  input  logic [CAUSE_W-1:0] cause_req,
  input  logic               req_any,
  input  logic               episode_start,
  input  logic               wr_status,
  input  logic [REG_W-1:0]   wr_data,
  output logic [FLAG_W-1:0]  flags_q,
  output logic               prio_q,
  output logic [CAUSE_W-1:0] cause_q
);
  logic [FLAG_W-1:0]  flags_d;
  logic               prio_d;
  logic [CAUSE_W-1:0] cause_d;

  always_comb begin
    flags_d = flags_q;
    prio_d  = prio_q;
    if (wr_status) begin
      flags_d = flags_q & wr_data[FLAG_W-1:0];
      prio_d  = wr_data[PRIO_BIT];
    end
    flags_d = flags_d | flag_set;
    if (por_evt) begin
      flags_d = FLAGS_AFTER_POR;
      prio_d  = 1'b0;
    end
  end

  always_comb begin
    cause_d = cause_q;
    if (req_any) cause_d = episode_start ? cause_req : (cause_q | cause_req);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      flags_q <= '0;
      prio_q  <= 1'b0;
    end else begin
      flags_q <= flags_d;
      prio_q  <= prio_d;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)      cause_q <= '0;
    else if (req_any) cause_q <= cause_d;
  end
endmodule

// File: rtl/reset_supervisor.sv
module reset_supervisor
  import rstc_pkg::*;
#(
  parameter int TERM_TICKS  = 2048,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = $clog2(TERM_TICKS + 1)
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             rc_tick,
  input  logic             por_req,
  input  logic             pin_rst_n,
  input  logic             wdt_req,
  input  logic             bor_req,
  input  logic             vreg_en,
  input  logic             cfg_mismatch_req,
  input  logic             swrst_req,
  input  logic             stk_full_req,
  input  logic             stk_under_req,
  input  logic             sleep_active,
  input  logic             reg_we,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             chip_rst
);
  localparam int NREQ = 8;

  logic [NREQ-1:0]    raw_req, sync_req;
  logic               por_s, wdt_s, bor_s, cfg_s, sw_s, full_s, under_s, sleep_s;
  logic               pin_ok_s, pin_s, pin_arst_n;
  logic               bor_ok, sleep_d;
  logic [CAUSE_W-1:0] cause_req;
  logic [FLAG_W-1:0]  flag_set;
  logic               req_any, episode_start, expired;
  logic               latch_q, latch_d;
  logic [CNT_W-1:0]   tmr_cnt;
  logic [FLAG_W-1:0]  flags_q;
  logic               prio_q;
  logic [CAUSE_W-1:0] cause_q;

  assign raw_req = {sleep_active, stk_under_req, stk_full_req, swrst_req,
                    cfg_mismatch_req, bor_req, wdt_req, por_req};

  rstc_sync #(.W(NREQ), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_req_sync (
    .clk(clk), .arst_n(arst_n), .d(raw_req), .q(sync_req)
  );
  assign {sleep_s, under_s, full_s, sw_s, cfg_s, bor_s, wdt_s, por_s} = sync_req;

  // pin: asserts through the flop reset, releases through the stages
  assign pin_arst_n = arst_n & pin_rst_n;
  rstc_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pin_sync (
    .clk(clk), .arst_n(pin_arst_n), .d(1'b1), .q(pin_ok_s)
  );
  assign pin_s  = ~pin_ok_s;
  assign bor_ok = bor_s & vreg_en;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sleep_d <= 1'b0;
    else         sleep_d <= sleep_s;
  end

  always_comb begin
    cause_req              = '0;
    cause_req[CS_POR]      = por_s;
    cause_req[CS_PIN_RUN]  = pin_s & ~sleep_s;
    cause_req[CS_PIN_SLP]  = pin_s &  sleep_s;
    cause_req[CS_WDT]      = wdt_s;
    cause_req[CS_BOR]      = bor_ok;
    cause_req[CS_CFG]      = cfg_s;
    cause_req[CS_SWRST]    = sw_s;
    cause_req[CS_STK_FULL] = full_s;
    cause_req[CS_STK_UNDR] = under_s;
  end

  always_comb begin
    flag_set           = '0;
    flag_set[FL_BOR]   = bor_ok;
    flag_set[FL_POR]   = por_s;
    flag_set[FL_SLEEP] = sleep_s & ~sleep_d;
    flag_set[FL_WDT]   = wdt_s;
    flag_set[FL_SWRST] = sw_s;
  end

  assign req_any       = |cause_req;
  assign episode_start = req_any & ~latch_q;

  rstc_timer #(.TERM_TICKS(TERM_TICKS)) u_timer (
    .clk(clk), .arst_n(arst_n), .run(latch_q), .restart(req_any),
    .tick(rc_tick), .expired(expired), .cnt(tmr_cnt)
  );

  // set/reset hold latch: set dominates release
  always_comb begin
    latch_d = latch_q;
    if (req_any)      latch_d = 1'b1;
    else if (expired) latch_d = 1'b0;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) latch_q <= 1'b1;
    else         latch_q <= latch_d;
  end
  assign chip_rst = latch_q;

  rstc_status u_status (
    .clk(clk), .arst_n(arst_n), .por_evt(por_s), .flag_set(flag_set),
    .cause_req(cause_req), .req_any(req_any), .episode_start(episode_start),
    .wr_status(reg_we & ~reg_addr), .wr_data(reg_wdata),
    .flags_q(flags_q), .prio_q(prio_q), .cause_q(cause_q)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr) begin
      reg_rdata[CAUSE_W-1:0] = cause_q;
    end else begin
      reg_rdata[FLAG_W-1:0] = flags_q;
      reg_rdata[PRIO_BIT]   = prio_q;
    end
  end
endmodule

// File: rtl/rstc_checker.sv
module rstc_checker
  import rstc_pkg::*;
#(
  parameter int TERM_TICKS = 2048,
  localparam int CNT_W = $clog2(TERM_TICKS + 1)
) (
  input logic              clk,
  input logic              arst_n,
  input logic              vreg_en,
  input logic              chip_rst,
  input logic              req_any,
  input logic              expired,
  input logic              por_s,
  input logic              bor_s,
  input logic [FLAG_W-1:0] flags_q,
  input logic [FLAG_W-1:0] flag_set,
  input logic              prio_q,
  input logic [CNT_W-1:0]  tmr_cnt
);
  a_r1_request_holds_reset: assert property (@(posedge clk) disable iff (!arst_n)
    req_any |=> chip_rst);

  a_r2_release_after_expiry: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(chip_rst) |-> $past(expired));

  a_r2_request_restarts_count: assert property (@(posedge clk) disable iff (!arst_n)
    req_any |=> (tmr_cnt == '0));

  a_r2_count_bounded: assert property (@(posedge clk) disable iff (!arst_n)
    tmr_cnt <= CNT_W'(TERM_TICKS));

  a_r3_bor_gated: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(flags_q[FL_BOR]) |-> $past(bor_s && vreg_en));

  a_r5_no_software_set: assert property (@(posedge clk) disable iff (!arst_n)
    (flags_q & ~$past(flags_q) & ~$past(flag_set)) == '0);

  a_r6_por_dominates: assert property (@(posedge clk) disable iff (!arst_n)
    $past(por_s) |-> (flags_q == FLAGS_AFTER_POR && !prio_q));
endmodule

bind reset_supervisor rstc_checker #(.TERM_TICKS(TERM_TICKS)) u_rstc_checker (.*);

// File: tb/tb_reset_supervisor.sv
module tb_reset_supervisor;
  localparam int TB_TERM = 5;
  localparam int NV = 12;

  logic clk = 1'b0;
  logic arst_n, rc_tick, por_req, pin_rst_n, wdt_req, bor_req, vreg_en;
  logic cfg_mismatch_req, swrst_req, stk_full_req, stk_under_req, sleep_active;
  logic reg_we, reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic chip_rst;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  reset_supervisor #(.TERM_TICKS(TB_TERM)) dut (
    .clk(clk), .arst_n(arst_n), .rc_tick(rc_tick), .por_req(por_req),
    .pin_rst_n(pin_rst_n), .wdt_req(wdt_req), .bor_req(bor_req), .vreg_en(vreg_en),
    .cfg_mismatch_req(cfg_mismatch_req), .swrst_req(swrst_req),
    .stk_full_req(stk_full_req), .stk_under_req(stk_under_req),
    .sleep_active(sleep_active), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .chip_rst(chip_rst)
  );

  // {exp_rst, vreg, sleep, req[7:0], flags[4:0], cause[8:0]}
  // req bits: 0 por, 1 pin, 2 wdt, 3 bor, 4 cfg, 5 swrst, 6 full, 7 under
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 1'b1, 1'b0, 8'h01, 5'b00010, 9'h001},  // power-on
    {1'b1, 1'b1, 1'b0, 8'h02, 5'b00000, 9'h002},  // pin, running
    {1'b1, 1'b1, 1'b1, 8'h02, 5'b00100, 9'h004},  // pin, low-power
    {1'b1, 1'b1, 1'b0, 8'h04, 5'b01000, 9'h008},  // watchdog
    {1'b1, 1'b1, 1'b0, 8'h08, 5'b00001, 9'h010},  // brown-out honoured
    {1'b0, 1'b0, 1'b0, 8'h08, 5'b00000, 9'h010},  // R3 brown-out gated
    {1'b1, 1'b1, 1'b0, 8'h10, 5'b00000, 9'h020},  // config mismatch
    {1'b1, 1'b1, 1'b0, 8'h20, 5'b10000, 9'h040},  // software reset
    {1'b1, 1'b1, 1'b0, 8'h40, 5'b00000, 9'h080},  // stack full
    {1'b1, 1'b1, 1'b0, 8'h80, 5'b00000, 9'h100},  // stack underflow
    {1'b1, 1'b1, 1'b0, 8'h2C, 5'b11001, 9'h058},  // R10 wdt+bor+sw
    {1'b1, 1'b1, 1'b0, 8'hD0, 5'b00000, 9'h1A0}   // R10 cfg+full+under
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) rc_tick = 1'b1;
      @(negedge clk) rc_tick = 1'b0;
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic drive(input logic [7:0] r);
    por_req = r[0]; pin_rst_n = ~r[1]; wdt_req = r[2]; bor_req = r[3];
    cfg_mismatch_req = r[4]; swrst_req = r[5]; stk_full_req = r[6]; stk_under_req = r[7];
  endtask

  task automatic pulse_wdt();
    @(negedge clk) wdt_req = 1'b1;
    @(negedge clk) wdt_req = 1'b0;
  endtask

  task automatic release_all(input string req);
    cyc(4);
    ticks(TB_TERM);
    @(negedge clk);
    chk(req, 32'(chip_rst), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rv;
    logic [24:0] v;
    arst_n = 1'b0; rc_tick = 1'b0; vreg_en = 1'b1; sleep_active = 1'b0;
    reg_we = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    drive(8'h00);
    cyc(3);
    chk("R11 chip_rst in reset", 32'(chip_rst), 32'd1);
    rd(1'b0, rv); chk("R11 status in reset", 32'(rv), 32'h0);
    rd(1'b1, rv); chk("R11 cause in reset", 32'(rv), 32'h0);
    @(negedge clk) arst_n = 1'b1;
    release_all("R2 release after reset");

    // table walk
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      wr(1'b0, 16'h0000);
      vreg_en = v[23]; sleep_active = v[22];
      cyc(4);
      drive(v[21:14]);
      cyc(3);
      drive(8'h00);
      cyc(4);
      chk("R1/R3 chip_rst after request", 32'(chip_rst), 32'(v[24]));
      rd(1'b0, rv); chk("R4/R6/R10 status flags", 32'(rv), 32'(v[13:9]));
      rd(1'b1, rv); chk("R8/R10 cause record", 32'(rv), 32'(v[8:0]));
      if (v[24]) begin
        ticks(TB_TERM);
        @(negedge clk);
        chk("R2 release after term ticks", 32'(chip_rst), 32'd0);
      end
      sleep_active = 1'b0; vreg_en = 1'b1;
      cyc(4);
    end

    // R1 latency of a one-cycle pulse
    pulse_wdt();
    @(negedge clk);
    chk("R1 not yet after two edges", 32'(chip_rst), 32'd0);
    @(negedge clk);
    chk("R1 asserted at third edge", 32'(chip_rst), 32'd1);
    release_all("R2 release after pulse");

    // R2 restart and exact boundary
    pulse_wdt();
    cyc(6);
    ticks(TB_TERM - 1);
    cyc(2);
    chk("R2 held one tick short", 32'(chip_rst), 32'd1);
    pulse_wdt();
    cyc(6);
    ticks(TB_TERM - 1);
    cyc(2);
    chk("R2 restarted count held", 32'(chip_rst), 32'd1);
    ticks(1);
    @(negedge clk);
    chk("R2 released on last tick", 32'(chip_rst), 32'd0);

    // R5 software can clear but not set
    wr(1'b0, 16'h0000);
    @(negedge clk) swrst_req = 1'b1;
    @(negedge clk) swrst_req = 1'b0;
    cyc(4);
    wr(1'b0, 16'h001F);
    rd(1'b0, rv); chk("R5 write ones sets nothing", 32'(rv), 32'h0010);
    wr(1'b0, 16'h000F);
    rd(1'b0, rv); chk("R5 write zero clears", 32'(rv), 32'h0000);
    release_all("R2 release after swrst");

    // R7 priority bit kept across a non power-on reset
    wr(1'b0, 16'h0080);
    rd(1'b0, rv); chk("R7 priority readback", 32'(rv), 32'h0080);
    pulse_wdt();
    cyc(4);
    rd(1'b0, rv); chk("R7 priority kept over watchdog", 32'(rv), 32'h0088);
    release_all("R2 release after wdt");

    // R6 power-on clears other flags and the priority bit
    @(negedge clk) por_req = 1'b1;
    @(negedge clk) por_req = 1'b0;
    cyc(4);
    rd(1'b0, rv); chk("R6 power-on status", 32'(rv), 32'h0002);

    // R8 cause word ignores writes
    wr(1'b1, 16'hFFFF);
    rd(1'b1, rv); chk("R8 cause write ignored", 32'(rv), 32'h0001);
    release_all("R2 release after por");

    // R9 pin asserts at the next edge
    @(negedge clk) pin_rst_n = 1'b0;
    @(posedge clk);
    #1 chk("R9 pin asserts at first edge", 32'(chip_rst), 32'd1);
    cyc(2);
    pin_rst_n = 1'b1;
    cyc(4);
    rd(1'b1, rv); chk("R9 pin while running cause", 32'(rv), 32'h0002);
    release_all("R2 release after pin");

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule